// File: doc/BRIEF.md
# Root-Port Traffic and Latency Monitor

This block watches inbound read and write requests that devices below a PCIe root complex send toward the memory system. Each request arrives with the root port it came through, its 16-bit requester ID, a read/write flag, a byte count and a destination class. A programmable source filter and a destination filter decide whether a request counts. Requests that pass are added to request and byte counters.

A separate strobe marks the completion of a monitored read. With it, the block keeps a live count of reads in flight and adds that count into a cumulative counter on every enabled cycle. A cycle counter runs alongside. Dividing the cumulative count by the read-request count gives the average read latency in cycles. Software does that division; the block does not.

A global enable freezes the counters while it is low. A synchronous clear zeroes them. The in-flight tracker is a true picture of the traffic, so neither the enable nor the clear touches it.

Top module: `rp_traffic_monitor`

## Requirements
- R1: With the root-port mask at zero, the requester-ID match disabled and the destination mask at zero, every valid request is counted, whatever its port and destination.
- R2: With the requester-ID match disabled and a nonzero root-port mask, a request counts only if mask bit i is set, where i is its 3-bit port index.
- R3: When `cfg_rid_en` is 1, a request counts only if its requester ID (bus in bits 15:8, device in bits 7:3, function in bits 2:0) equals `cfg_rid_val`. The root-port mask is then ignored.
- R4: Destination codes are 0 system memory, 1 GPU memory, 2 PCIe peer, 3 CXL memory and 4 remote. A nonzero `cfg_dst_mask` counts a request only if the bit named by its code is set; codes 5 to 7 then never count. A zero mask counts all codes.
- R5: Each counted read adds 1 to the read-request counter and its byte count to the read-byte counter. Each counted write does the same on the write-request and write-byte counters.
- R6: The in-flight level on `rd_outstanding` rises by 1 after an accepted read and falls by 1 after a completion strobe. A read and a completion in the same cycle leave it unchanged.
- R7: On each enabled cycle, the cumulative counter adds the in-flight level held before that clock edge, and the cycle counter adds 1.
- R8: The in-flight level saturates at 2^OUTS_W-1 and never goes below zero.
- R9: While `cnt_en` is 0, all six counters hold their values and the in-flight level keeps tracking.
- R10: `cnt_clr` zeroes all six counters at the next edge. It takes priority over `cnt_en` and leaves the in-flight level alone.
- R11: After reset, all counters and the in-flight level read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Global count enable |
| cnt_clr | input | 1 | Synchronous clear of all counters |
| cfg_rp_mask | input | 8 | Root-port select mask (0 = all ports) |
| cfg_rid_en | input | 1 | Use the requester-ID match instead of the port mask |
| cfg_rid_val | input | 16 | Requester ID to match |
| cfg_dst_mask | input | 5 | Destination class select mask (0 = all classes) |
| txn_valid | input | 1 | Request present this cycle |
| txn_port | input | 3 | Root-port index of the request |
| txn_rid | input | 16 | Requester ID of the request |
| txn_write | input | 1 | 1 = write, 0 = read |
| txn_bytes | input | 13 | Byte count of the request |
| txn_dst | input | 3 | Destination class code |
| rd_cpl | input | 1 | Completion of one monitored read |
| rd_req_cnt | output | 64 | Counted read requests |
| wr_req_cnt | output | 64 | Counted write requests |
| rd_byte_cnt | output | 64 | Bytes of counted reads |
| wr_byte_cnt | output | 64 | Bytes of counted writes |
| cum_outs_cnt | output | 64 | Sum of the in-flight level over enabled cycles |
| cycle_cnt | output | 64 | Enabled cycles |
| rd_outstanding | output | 6 | Present in-flight read level |

## Verification
The bench programs a requester-ID match that points at a port the mask excludes. A design that still applied the port mask would drop those requests. It sends destination codes above 4 under a nonzero mask; a design that indexed the mask blindly would count them. It issues a read and a completion in the same cycle and expects the level to stay put, then pushes the level past its ceiling and pulls it below zero. A wrapping tracker would show a small value or all ones. Finally it lowers the enable while reads continue and raises the clear together with the enable. A design that froze the tracker, or let the enable win over the clear, would show counts that differ from the bench's own model.

// File: rtl/rtm_pkg.sv
package rtm_pkg;
    // event slots of the counter bank
    localparam int NUM_EV      = 6;
    localparam int EV_RD_REQ   = 0;
    localparam int EV_WR_REQ   = 1;
    localparam int EV_RD_BYTES = 2;
    localparam int EV_WR_BYTES = 3;
    localparam int EV_CUM_OUTS = 4;
    localparam int EV_CYCLES   = 5;

    // destination classes
    localparam int NUM_DST     = 5;
    typedef enum logic [2:0] {
        DST_SYSMEM = 3'd0,
        DST_GPUMEM = 3'd1,
        DST_PEER   = 3'd2,
        DST_CXL    = 3'd3,
        DST_REMOTE = 3'd4
    } dst_class_e;
endpackage

// File: rtl/rtm_filter.sv
module rtm_filter #(
    parameter int NUM_PORTS = 8,
    parameter int RID_W     = 16,
    parameter int NUM_DST   = 5,
    parameter int DST_W     = 3,
    localparam int PORT_W   = $clog2(NUM_PORTS)
) (
    input  logic [PORT_W-1:0]    port,
    input  logic [RID_W-1:0]     rid,
    input  logic [DST_W-1:0]     dst,
    input  logic [NUM_PORTS-1:0] rp_mask,
    input  logic                 rid_en,
    input  logic [RID_W-1:0]     rid_val,
    input  logic [NUM_DST-1:0]   dst_mask,
    output logic                 hit
);
    logic src_ok;
    logic dst_ok;
    logic dst_in_range;

    always_comb begin
        if (rid_en) begin
            src_ok = (rid == rid_val);
        end else if (rp_mask == '0) begin
            src_ok = 1'b1;
        end else begin
            src_ok = rp_mask[port];
        end
    end

    assign dst_in_range = ({{(32-DST_W){1'b0}}, dst} < NUM_DST);

    always_comb begin
        if (dst_mask == '0) begin
            dst_ok = 1'b1;
        end else if (dst_in_range) begin
            dst_ok = dst_mask[dst[$clog2(NUM_DST)-1:0]];
        end else begin
            dst_ok = 1'b0;
        end
    end

    assign hit = src_ok && dst_ok;
endmodule

// File: rtl/rtm_outstanding.sv
module rtm_outstanding #(
    parameter int OUTS_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_issue,
    input  logic              rd_cpl,
    output logic [OUTS_W-1:0] level
);
    localparam logic [OUTS_W-1:0] LEVEL_MAX = '1;

    typedef struct packed {
        logic [OUTS_W-1:0] level;
    } outs_state_t;

    outs_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_issue && !rd_cpl) begin
            if (st_q.level != LEVEL_MAX) st_d.level = st_q.level + 1'b1;
        end else if (rd_cpl && !rd_issue) begin
            if (st_q.level != '0) st_d.level = st_q.level - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.level;

    a_r8_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (level == LEVEL_MAX && rd_issue && !rd_cpl) |=> level == LEVEL_MAX);
    a_r8_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && rd_cpl && !rd_issue) |=> level == '0);
    a_r6_pair_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_issue == rd_cpl) |=> $stable(level));
    a_r6_issue_rises: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_issue && !rd_cpl && level != LEVEL_MAX) |=> level == $past(level) + 1'b1);
endmodule

// File: rtl/rtm_counters.sv
module rtm_counters #(
    parameter int CNT_W  = 64,
    parameter int NUM_EV = 6
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         en,
    input  logic                         clr,
    input  logic [NUM_EV-1:0][CNT_W-1:0] add,
    output logic [NUM_EV-1:0][CNT_W-1:0] cnt
);
    genvar g;
    generate
        for (g = 0; g < NUM_EV; g++) begin : g_slot
            logic [CNT_W-1:0] cnt_d, cnt_q;

            always_comb begin
                cnt_d = cnt_q;
                if (clr)     cnt_d = '0;
                else if (en) cnt_d = cnt_q + add[g];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) cnt_q <= '0;
                else        cnt_q <= cnt_d;
            end

            assign cnt[g] = cnt_q;

            a_r10_clear: assert property (@(posedge clk) disable iff (!rst_n)
                clr |=> cnt[g] == '0);
            a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (!en && !clr) |=> $stable(cnt[g]));
        end
    endgenerate
endmodule

// File: rtl/rp_traffic_monitor.sv
module rp_traffic_monitor #(
    parameter int NUM_PORTS = 8,
    parameter int RID_W     = 16,
    parameter int BYTE_W    = 13,
    parameter int CNT_W     = 64,
    parameter int OUTS_W    = 6,
    localparam int PORT_W   = $clog2(NUM_PORTS),
    localparam int NUM_DST  = rtm_pkg::NUM_DST,
    localparam int DST_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cnt_en,
    input  logic                 cnt_clr,
    input  logic [NUM_PORTS-1:0] cfg_rp_mask,
    input  logic                 cfg_rid_en,
    input  logic [RID_W-1:0]     cfg_rid_val,
    input  logic [NUM_DST-1:0]   cfg_dst_mask,
    input  logic                 txn_valid,
    input  logic [PORT_W-1:0]    txn_port,
    input  logic [RID_W-1:0]     txn_rid,
    input  logic                 txn_write,
    input  logic [BYTE_W-1:0]    txn_bytes,
    input  logic [DST_W-1:0]     txn_dst,
    input  logic                 rd_cpl,
    output logic [CNT_W-1:0]     rd_req_cnt,
    output logic [CNT_W-1:0]     wr_req_cnt,
    output logic [CNT_W-1:0]     rd_byte_cnt,
    output logic [CNT_W-1:0]     wr_byte_cnt,
    output logic [CNT_W-1:0]     cum_outs_cnt,
    output logic [CNT_W-1:0]     cycle_cnt,
    output logic [OUTS_W-1:0]    rd_outstanding
);
    import rtm_pkg::*;

    logic                         hit;
    logic                         acc_rd;
    logic                         acc_wr;
    logic [NUM_EV-1:0][CNT_W-1:0] add;
    logic [NUM_EV-1:0][CNT_W-1:0] cnt;
    logic [CNT_W-1:0]             bytes_ext;
    logic [CNT_W-1:0]             level_ext;

    rtm_filter #(
        .NUM_PORTS(NUM_PORTS), .RID_W(RID_W), .NUM_DST(NUM_DST), .DST_W(DST_W)
    ) u_filter (
        .port(txn_port), .rid(txn_rid), .dst(txn_dst),
        .rp_mask(cfg_rp_mask), .rid_en(cfg_rid_en), .rid_val(cfg_rid_val),
        .dst_mask(cfg_dst_mask), .hit(hit)
    );

    assign acc_rd = txn_valid && hit && !txn_write;
    assign acc_wr = txn_valid && hit && txn_write;

    rtm_outstanding #(.OUTS_W(OUTS_W)) u_outs (
        .clk(clk), .rst_n(rst_n), .rd_issue(acc_rd), .rd_cpl(rd_cpl),
        .level(rd_outstanding)
    );

    assign bytes_ext = {{(CNT_W-BYTE_W){1'b0}}, txn_bytes};
    assign level_ext = {{(CNT_W-OUTS_W){1'b0}}, rd_outstanding};

    always_comb begin
        add              = '0;
        add[EV_RD_REQ]   = acc_rd ? CNT_W'(1) : '0;
        add[EV_WR_REQ]   = acc_wr ? CNT_W'(1) : '0;
        add[EV_RD_BYTES] = acc_rd ? bytes_ext : '0;
        add[EV_WR_BYTES] = acc_wr ? bytes_ext : '0;
        add[EV_CUM_OUTS] = level_ext;
        add[EV_CYCLES]   = CNT_W'(1);
    end

    rtm_counters #(.CNT_W(CNT_W), .NUM_EV(NUM_EV)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(cnt_en), .clr(cnt_clr),
        .add(add), .cnt(cnt)
    );

    assign rd_req_cnt   = cnt[EV_RD_REQ];
    assign wr_req_cnt   = cnt[EV_WR_REQ];
    assign rd_byte_cnt  = cnt[EV_RD_BYTES];
    assign wr_byte_cnt  = cnt[EV_WR_BYTES];
    assign cum_outs_cnt = cnt[EV_CUM_OUTS];
    assign cycle_cnt    = cnt[EV_CYCLES];

    a_r3_rid_mismatch_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && cfg_rid_en && txn_rid != cfg_rid_val && !cnt_clr)
        |=> $stable(rd_req_cnt) && $stable(wr_req_cnt));
    a_r2_port_excluded: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_valid && !cfg_rid_en && cfg_rp_mask != '0 && !cfg_rp_mask[txn_port] && !cnt_clr)
        |=> $stable(rd_req_cnt) && $stable(wr_req_cnt));
    a_r7_cum_adds_level: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_clr) |=> cum_outs_cnt == $past(cum_outs_cnt) + $past(level_ext));
    a_r7_cycle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !cnt_clr) |=> cycle_cnt == $past(cycle_cnt) + 1'b1);
endmodule

// File: tb/rp_traffic_monitor_bench.sv
module rp_traffic_monitor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LVL_MAX    = 63;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0, cnt_clr = 1'b0;
    logic [7:0]  cfg_rp_mask = '0;
    logic        cfg_rid_en = 1'b0;
    logic [15:0] cfg_rid_val = '0;
    logic [4:0]  cfg_dst_mask = '0;
    logic        txn_valid = 1'b0;
    logic [2:0]  txn_port = '0;
    logic [15:0] txn_rid = '0;
    logic        txn_write = 1'b0;
    logic [12:0] txn_bytes = '0;
    logic [2:0]  txn_dst = '0;
    logic        rd_cpl = 1'b0;
    logic [63:0] rd_req_cnt, wr_req_cnt, rd_byte_cnt, wr_byte_cnt, cum_outs_cnt, cycle_cnt;
    logic [5:0]  rd_outstanding;

    int n_checks = 0;
    int n_fail   = 0;
    longint unsigned e_rd = 0, e_wr = 0, e_rdb = 0, e_wrb = 0, e_cum = 0, e_cyc = 0;
    int e_lvl = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rp_traffic_monitor u_rp_traffic_monitor (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cnt_clr(cnt_clr),
        .cfg_rp_mask(cfg_rp_mask), .cfg_rid_en(cfg_rid_en), .cfg_rid_val(cfg_rid_val),
        .cfg_dst_mask(cfg_dst_mask), .txn_valid(txn_valid), .txn_port(txn_port),
        .txn_rid(txn_rid), .txn_write(txn_write), .txn_bytes(txn_bytes),
        .txn_dst(txn_dst), .rd_cpl(rd_cpl), .rd_req_cnt(rd_req_cnt),
        .wr_req_cnt(wr_req_cnt), .rd_byte_cnt(rd_byte_cnt), .wr_byte_cnt(wr_byte_cnt),
        .cum_outs_cnt(cum_outs_cnt), .cycle_cnt(cycle_cnt), .rd_outstanding(rd_outstanding)
    );

    function automatic bit model_hit(input logic [2:0] p, input logic [15:0] rid,
                                     input logic [2:0] d);
        bit s, k;
        if (cfg_rid_en)              s = (rid == cfg_rid_val);
        else if (cfg_rp_mask == '0)  s = 1'b1;
        else                         s = cfg_rp_mask[p];
        if (cfg_dst_mask == '0)      k = 1'b1;
        else if (d < 3'd5)           k = cfg_dst_mask[d];
        else                         k = 1'b0;
        return s && k;
    endfunction

    // one clock of stimulus; starts and ends just after a falling edge
    task automatic cyc(input bit v, input logic [2:0] p, input logic [15:0] rid,
                       input bit wr, input int b, input logic [2:0] d, input bit cpl);
        bit acc, rd;
        txn_valid = v; txn_port = p; txn_rid = rid; txn_write = wr;
        txn_bytes = 13'(b); txn_dst = d; rd_cpl = cpl;
        acc = v && model_hit(p, rid, d);
        rd  = acc && !wr;
        if (cnt_clr) begin
            e_rd = 0; e_wr = 0; e_rdb = 0; e_wrb = 0; e_cum = 0; e_cyc = 0;
        end else if (cnt_en) begin
            e_cum += longint'(e_lvl);
            e_cyc += 1;
            if (acc && !wr) begin e_rd += 1; e_rdb += longint'(b); end
            if (acc &&  wr) begin e_wr += 1; e_wrb += longint'(b); end
        end
        if (rd && !cpl && e_lvl < LVL_MAX) e_lvl++;
        else if (cpl && !rd && e_lvl > 0)  e_lvl--;
        @(posedge clk);
        @(negedge clk);
        txn_valid = 1'b0; rd_cpl = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 3'd0, 16'h0, 0, 0, 3'd0, 0);
    endtask

    task automatic chk(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "rd_req_cnt",     rd_req_cnt,     e_rd);
        chk(req, "wr_req_cnt",     wr_req_cnt,     e_wr);
        chk(req, "rd_byte_cnt",    rd_byte_cnt,    e_rdb);
        chk(req, "wr_byte_cnt",    wr_byte_cnt,    e_wrb);
        chk(req, "cum_outs_cnt",   cum_outs_cnt,   e_cum);
        chk(req, "cycle_cnt",      cycle_cnt,      e_cyc);
        chk(req, "rd_outstanding", longint'(rd_outstanding), longint'(e_lvl));
    endtask

    task automatic drain();
        while (e_lvl > 0) cyc(0, 3'd0, 16'h0, 0, 0, 3'd0, 1);
    endtask

    // R11: everything zero out of reset
    task automatic t_reset();
        check_all("R11");
        chk("R11", "rd_outstanding zero", longint'(rd_outstanding), 0);
    endtask

    // R1 and R5: no filters, mixed ports, destinations, reads and writes
    task automatic t_no_filter();
        cfg_rp_mask = '0; cfg_rid_en = 0; cfg_dst_mask = '0;
        cyc(1, 3'd0, 16'h0100, 0, 64,  3'd0, 0);
        cyc(1, 3'd7, 16'h0200, 1, 128, 3'd4, 0);
        cyc(1, 3'd3, 16'h0300, 0, 32,  3'd6, 0);
        cyc(1, 3'd5, 16'h0400, 1, 4096, 3'd2, 0);
        idle(2);
        check_all("R1");
        chk("R5", "wr bytes sum", wr_byte_cnt, e_wrb);
        drain(); idle(1);
        check_all("R5");
    endtask

    // R2: mask 0x05 keeps ports 0 and 2 only
    task automatic t_port_mask();
        cfg_rp_mask = 8'h05;
        cyc(1, 3'd0, 16'h0, 1, 8,  3'd0, 0);
        cyc(1, 3'd1, 16'h0, 1, 16, 3'd0, 0);
        cyc(1, 3'd2, 16'h0, 0, 24, 3'd1, 0);
        cyc(1, 3'd7, 16'h0, 0, 40, 3'd1, 0);
        idle(1);
        check_all("R2");
        drain();
    endtask

    // R3: bus 0x12 dev 5 fn 3 packs to 0x122B; port mask excludes the port used
    task automatic t_rid();
        cfg_rp_mask = 8'h01; cfg_rid_en = 1; cfg_rid_val = {8'h12, 5'd5, 3'd3};
        cyc(1, 3'd3, 16'h122B, 0, 100, 3'd0, 0);
        cyc(1, 3'd0, 16'h122A, 1, 200, 3'd0, 0);
        cyc(1, 3'd0, 16'h132B, 0, 300, 3'd0, 0);
        cyc(1, 3'd6, 16'h122B, 1, 50,  3'd3, 0);
        idle(1);
        check_all("R3");
        cfg_rid_en = 0; cfg_rp_mask = '0;
        drain();
    endtask

    // R4: only GPU memory (1) and remote (4); codes 5..7 rejected
    task automatic t_dst();
        cfg_dst_mask = 5'b10010;
        for (int d = 0; d < 8; d++) cyc(1, 3'd1, 16'h0, 1, d + 1, 3'(d), 0);
        idle(1);
        check_all("R4");
        cfg_dst_mask = '0;
    endtask

    // R6 and R7: level steps and cumulative sum
    task automatic t_outstanding();
        drain(); idle(1);
        cyc(1, 3'd0, 16'h0, 0, 4, 3'd0, 0);
        cyc(1, 3'd0, 16'h0, 0, 4, 3'd0, 0);
        cyc(1, 3'd0, 16'h0, 0, 4, 3'd0, 0);
        chk("R6", "level after 3 reads", longint'(rd_outstanding), 3);
        cyc(1, 3'd0, 16'h0, 0, 4, 3'd0, 1);   // read and completion together
        chk("R6", "level unchanged on pair", longint'(rd_outstanding), 3);
        cyc(0, 3'd0, 16'h0, 0, 0, 3'd0, 1);
        chk("R6", "level after completion", longint'(rd_outstanding), 2);
        idle(3);
        check_all("R7");
        // filtered-out read does not raise the level
        cfg_rp_mask = 8'h02;
        cyc(1, 3'd0, 16'h0, 0, 4, 3'd0, 0);
        chk("R6", "filtered read ignored", longint'(rd_outstanding), 2);
        cfg_rp_mask = '0;
        drain();
    endtask

    // R8: saturation and no underflow
    task automatic t_saturate();
        for (int i = 0; i < 70; i++) cyc(1, 3'd2, 16'h0, 0, 1, 3'd0, 0);
        chk("R8", "level saturated", longint'(rd_outstanding), LVL_MAX);
        for (int i = 0; i < 66; i++) cyc(0, 3'd0, 16'h0, 0, 0, 3'd0, 1);
        chk("R8", "level floors at zero", longint'(rd_outstanding), 0);
        check_all("R8");
    endtask

    // R9 and R10: enable low holds counters, tracker moves; clear beats enable
    task automatic t_en_clr();
        cnt_en = 0;
        cyc(1, 3'd1, 16'h0, 0, 64, 3'd0, 0);
        cyc(1, 3'd1, 16'h0, 1, 64, 3'd0, 0);
        idle(2);
        check_all("R9");
        chk("R9", "tracker still counts", longint'(rd_outstanding), 1);
        cnt_en = 1; cnt_clr = 1;
        cyc(1, 3'd1, 16'h0, 0, 64, 3'd0, 0);
        cnt_clr = 0;
        check_all("R10");
        chk("R10", "rd_req_cnt zero", rd_req_cnt, 0);
        chk("R10", "level kept", longint'(rd_outstanding), 2);
        idle(2);
        check_all("R10");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        cnt_en = 1'b1;
        t_no_filter();
        t_port_mask();
        t_rid();
        t_dst();
        t_outstanding();
        t_saturate();
        t_en_clr();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule